// File: doc/BRIEF.md
# Cluster Token Lock Arbiter

This block is the middle tier of a two-level hardware lock tree, and it serves a single lock. A small group of core-side controllers sits below it, and one of them is the core that shares the cluster with the arbiter. Each child signals through a single 1-bit pulse line that carries both its request and its release. The arbiter keeps one pending flag per child. A pulse on a child's line toggles that child's flag. A pulse while the flag is clear is a request. A pulse while the flag is set is a release, or a withdrawal of a request that has not yet been granted.

When requests are waiting, the arbiter sends one pulse up to the root arbiter and waits for the root's token. While it owns the lock, it hands a one-cycle token to the pending children in rising index order. A release by the current holder moves the token to the next pending child without any traffic to the root. When no pending child lies beyond the last holder, the arbiter drops ownership and sends a release pulse to the root. A child that was already passed in the current ownership period keeps its flag set. It is served in the next period, after a fresh upstream request.

Top module: `cluster_lock_mgr`

## Requirements
- R1: While reset is held, and afterwards until a child pulses, every child token output and the upstream pulse output stay 0. Reset clears all pending flags.
- R2: A pulse on `child_pulse[i]` while child i's flag is clear sets the flag. A pulse while the flag is set clears it, so a child that withdraws before being granted receives no token. Index 0 is the co-located core and follows the same rules.
- R3: In the cycle after the first pending flag becomes set, while the arbiter owns nothing, `up_pulse` is high for exactly one cycle. No further upstream pulse follows while the arbiter waits for the root.
- R4: When `up_token` is high in a cycle while the arbiter waits, ownership is taken at the next edge. The token then goes to the lowest-indexed pending child two cycles after the `up_token` cycle.
- R5: When the holder pulses its line, the next pending child with a higher index receives the token in the following cycle, and `up_pulse` stays 0.
- R6: When the holder releases and no pending child has a higher index, `up_pulse` is high in the following cycle as a release, and no token is issued.
- R7: A child that requests after it has been passed in the current period gets no token in that period. The arbiter raises a new upstream request in the cycle after its release pulse, and serves that child after the next root token.
- R8: At most one child token is high in any cycle. Each token is a one-cycle pulse, and a token is never high in the same cycle as `up_pulse`.
- R9: `up_token` is ignored unless the arbiter is waiting for it. A stray root token during a hold produces no extra child token.
- R10: If every pending flag has been withdrawn by the time the root token arrives, the arbiter issues no child token. It sends a release pulse two cycles after the `up_token` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| child_pulse | input | N_CHILD | Per-child request/release pulse; bit 0 is the co-located core's flag write |
| child_token | output | N_CHILD | Per-child one-cycle token grant |
| up_pulse | output | 1 | One-cycle pulse to the root: request when idle, release at the end of a pass |
| up_token | input | 1 | One-cycle token from the root granting ownership |

## Verification
Every output of the block is registered, so a result is due a fixed number of cycles after its stimulus:
- A child pulse shows on `up_pulse` two cycles later: one cycle to set the flag and one to register the pulse.
- A root token reaches a child token two cycles after its cycle.
- A holder's release moves the token, or raises the release pulse, in the very next cycle.

The bench drives each cycle's inputs just after the falling edge. At that same point it compares the outputs registered at the preceding rising edge with the expected value for that cycle, so every expected value is tied to one exact cycle. A withdrawal that is ignored or takes effect is judged by whether a token or upstream pulse appears in that cycle.

// File: rtl/cluster_lock_mgr.sv
module cluster_lock_mgr #(
  parameter int N_CHILD = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CHILD-1:0] child_pulse,
  output logic [N_CHILD-1:0] child_token,
  output logic               up_pulse,
  input  logic               up_token
);
  localparam int PW = $clog2(N_CHILD + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PICK, S_HOLD} st_t;

  st_t               st;
  logic              own;
  logic [N_CHILD-1:0] pend;
  logic [PW-1:0]     ptr;
  logic [PW-1:0]     holder;
  logic [PW-1:0]     nxt;
  logic              hit;
  logic              rel;

  always_comb begin
    hit = 1'b0;
    nxt = '0;
    for (int i = N_CHILD - 1; i >= 0; i--) begin
      if (pend[i] && (PW'(i) >= ptr)) begin
        hit = 1'b1;
        nxt = PW'(i);
      end
    end
  end

  assign rel = (st == S_HOLD) && child_pulse[holder] && pend[holder];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      own         <= 1'b0;
      pend        <= '0;
      ptr         <= '0;
      holder      <= '0;
      child_token <= '0;
      up_pulse    <= 1'b0;
    end else begin
      pend        <= pend ^ child_pulse;
      child_token <= '0;
      up_pulse    <= 1'b0;
      case (st)
        S_IDLE: if (|pend) begin
          up_pulse <= 1'b1;
          st       <= S_WAIT;
        end
        S_WAIT: if (up_token) begin
          own <= 1'b1;
          ptr <= '0;
          st  <= S_PICK;
        end
        S_PICK, S_HOLD: if (st == S_PICK || rel) begin
          if (hit) begin
            child_token <= N_CHILD'(1) << nxt;
            holder      <= nxt;
            ptr         <= nxt + PW'(1);
            st          <= S_HOLD;
          end else begin
            own      <= 1'b0;
            up_pulse <= 1'b1;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(child_token));

  assert_token_vs_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_pulse |-> (child_token == '0));

  assert_token_needs_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|child_token) |-> own);

  assert_wait_then_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && up_token) |=> own);

  for (genvar g = 0; g < N_CHILD; g++) begin : g_chk
    assert_token_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      child_token[g] |=> !child_token[g]);
    assert_token_to_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (child_token[g] && $past(rst_n)) |-> $past(pend[g]));
  end
endmodule

// File: tb/test_cluster_lock_mgr.sv
module test_cluster_lock_mgr;
  localparam int N = 3;
  localparam int NV = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] child_pulse = '0;
  logic [N-1:0] child_token;
  logic         up_pulse;
  logic         up_token = 1'b0;

  int  applied = 0;
  int  bad = 0;
  int  cycles = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  cluster_lock_mgr #(.N_CHILD(N)) i_cluster_lock_mgr (
    .clk(clk), .rst_n(rst_n), .child_pulse(child_pulse),
    .child_token(child_token), .up_pulse(up_pulse), .up_token(up_token)
  );

  // {pulse[2:0], up_token, expected token[2:0], expected up_pulse}
  localparam logic [7:0] VEC [NV] = '{
    8'b111_0_000_0, // 0  R2 all three request
    8'b000_0_000_0, // 1  R3 flags set, pulse next
    8'b000_1_000_1, // 2  R3 upstream request, R4 root token
    8'b000_0_000_0, // 3  R4 ownership taken
    8'b000_0_001_0, // 4  R4 lowest index granted
    8'b001_0_000_0, // 5  R5 holder 0 releases
    8'b001_0_010_0, // 6  R5 child 1 granted; R7 child 0 re-requests
    8'b010_0_000_0, // 7  R5 holder 1 releases
    8'b000_1_100_0, // 8  R5 child 2 granted; R9 stray root token
    8'b000_0_000_0, // 9  R9 no extra token
    8'b100_0_000_0, // 10 R6 last holder releases
    8'b000_0_000_1, // 11 R6 release to root
    8'b000_0_000_1, // 12 R7 fresh request right after
    8'b000_1_000_0, // 13 R7 root token
    8'b000_0_000_0, // 14 R7
    8'b001_0_001_0, // 15 R7 child 0 served, releases at once
    8'b000_0_000_1, // 16 R6 pass over, release
    8'b010_0_000_0, // 17 R3 quiet, then child 1 requests
    8'b000_0_000_0, // 18 R3
    8'b010_0_000_1, // 19 R3 request up; R2 child 1 withdraws
    8'b000_1_000_0, // 20 R10 root token with nothing pending
    8'b000_0_000_0, // 21 R10
    8'b000_0_000_1, // 22 R10 release, no token
    8'b000_0_000_0  // 23 R2 quiet
  };

  function automatic string tag_of(int k);
    case (k)
      0, 19, 23:          return "R2";
      1, 2, 17, 18:       return "R3";
      3, 4:               return "R4";
      5, 6, 7, 8:         return "R5";
      10, 11, 16:         return "R6";
      12, 13, 14, 15:     return "R7";
      9:                  return "R9";
      default:            return "R10";
    endcase
  endfunction

  task automatic check(input logic [N-1:0] et, input logic eu, input string tag);
    applied++;
    if (child_token !== et || up_pulse !== eu) begin
      bad++;
      $display("FAIL %s: token=%b up=%b expected token=%b up=%b",
               tag, child_token, up_pulse, et, eu);
    end
  endtask

  task automatic step(input logic [N-1:0] p, input logic t,
                      input logic [N-1:0] et, input logic eu, input string tag);
    check(et, eu, tag);
    child_pulse = p;
    up_token    = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check('0, 1'b0, "R1");
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][7:5], VEC[k][4], VEC[k][3:1], VEC[k][0], tag_of(k));
    end
    // only the highest index requests: R4 lowest pending is index 2
    step(3'b100, 1'b0, '0, 1'b0, "R3");
    step(3'b000, 1'b0, '0, 1'b0, "R3");
    step(3'b000, 1'b1, '0, 1'b1, "R3");
    step(3'b000, 1'b0, '0, 1'b0, "R4");
    step(3'b011, 1'b0, 3'b100, 1'b0, "R4");
    // reset during a hold clears flags and ownership (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check('0, 1'b0, "R1");
    rst_n = 1'b1;
    child_pulse = '0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) step('0, 1'b0, '0, 1'b0, "R1");
    // flags were cleared: a new request is served from index 0 (R1)
    step(3'b001, 1'b0, '0, 1'b0, "R1");
    step(3'b000, 1'b0, '0, 1'b0, "R1");
    step(3'b000, 1'b1, '0, 1'b1, "R1");
    step(3'b000, 1'b0, '0, 1'b0, "R1");
    step(3'b001, 1'b0, 3'b001, 1'b0, "R1");
    step(3'b000, 1'b0, '0, 1'b1, "R6");
    step(3'b000, 1'b0, '0, 1'b0, "R6");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule